// File: doc/BRIEF.md
# Per-Channel Sample Word Packer

This block takes a stream of 16-bit samples, one per cycle in which the sample enable is high, and regroups them by channel. Samples are gathered in blocks of 64, called atoms. For every channel that is switched on, an atom yields one 64-bit word that holds that channel's history across the atom. Those words leave on a 64-bit valid/ready stream, one per accepted handshake, before the words of the next atom.

A capture begins with a start strobe. The strobe also captures the channel-enable mask and the sample limit. The limit counts 16-sample units. Packing is double buffered, so one atom fills while the words of the previous atom drain. If the consumer falls an atom behind, the newer atom is discarded and a sticky overflow flag is raised. When the limit ends partway through an atom, the atom is padded with zeros and still sent. A done flag marks the point at which every word of the capture has been accepted.

Back-pressure rules: the consumer may hold `out_ready_i` low for any length of time. While `out_valid_o` is high and `out_ready_i` is low, the block holds both `out_valid_o` and `out_data_o` unchanged. A word is consumed on a rising clock edge where `out_valid_o` and `out_ready_i` are both high. The sample input has no back-pressure. Samples that arrive while the drain is blocked can only lead to overflow.

Top module: `chan_word_packer`

## Requirements
- R1: After reset, `out_valid_o`, `done_o` and `overflow_o` are 0. Sample enables that come before the first start strobe produce no output and do not raise `done_o`.
- R2: An atom is 64 consecutive accepted samples. Bit n (bit 0 is the LSB) of a channel's word equals that channel's bit of sample n within the atom.
- R3: Within an atom, words are emitted in ascending channel-index order. All words of one atom are emitted before any word of the next atom.
- R4: A channel whose mask bit is 0 emits no words. Each atom therefore yields exactly popcount(mask) words, and a zero mask yields no words at all.
- R5: A capture accepts exactly `limit_i`*16 samples, and any further sample enables are ignored. With a limit of 0 the capture emits nothing, and `done_o` is high right after the start edge.
- R6: If the limit ends inside an atom, the bits of that atom beyond the last sample are 0, and the atom's words are still emitted.
- R7: A start strobe discards every partial atom and every pending word. At the strobe the block latches `chan_mask_i` and `limit_i`, and later changes to these inputs are ignored until the next strobe. A sample enable in the same cycle as the strobe is ignored. The cycle after the strobe has `out_valid_o` and `overflow_o` at 0.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the next cycle keeps `out_valid_o` at 1 and `out_data_o` unchanged.
- R9: An atom overflows when it completes while the previous atom still has words pending, unless the last of those words is accepted on that same edge. An overflowing atom is discarded, and `overflow_o` goes to 1 and stays there until the next start strobe.
- R10: `done_o` goes high in the cycle right after the edge that accepts the capture's final word. If there are no words, it goes high right after the final sample is taken. It stays high until the next start, and `out_valid_o` is 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe: clears state, latches mask and limit |
| sample_en_i | input | 1 | Take `sample_i` this cycle |
| sample_i | input | NUM_CH | One bit per channel |
| chan_mask_i | input | NUM_CH | Channel enable mask, latched at start |
| limit_i | input | LIMIT_W | Capture length in 16-sample units, latched at start |
| out_valid_o | output | 1 | Packed word available |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | ATOM_LEN | Packed channel word |
| done_o | output | 1 | Capture complete and fully drained |
| overflow_o | output | 1 | Sticky: an atom was discarded |

## Verification
The bench targets limits that stop inside an atom. A packer that left stale bits, or that skipped the partial atom, would produce a wrong final word or a missing final word. It uses sparse masks and an all-zero mask to catch a round-robin that visits disabled lanes or reorders channels. It restarts a capture midway and drives a sample enable in the same cycle as the strobe; a design that kept partial bits would show old samples in the first atom. It also holds ready low across two atoms. A design that overwrote the draining buffer, instead of discarding the new atom and flagging it, would emit mixed words. Finally, it checks that done rises exactly one cycle after the final handshake, with no early or late completion.

// File: rtl/packer_pkg.sv
package packer_pkg;

  // Index of the lowest set bit of a vector; 0 when the vector is empty.
  function automatic int first_set(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/pk_sample_counter.sv
module pk_sample_counter #(
  parameter int LIMIT_W   = 24,
  parameter int UNIT_LOG2 = 4,
  parameter int ATOM_LEN  = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         sample_en_i,
  input  logic [LIMIT_W-1:0]           limit_i,
  output logic                         take_o,
  output logic [$clog2(ATOM_LEN)-1:0]  bit_idx_o,
  output logic                         atom_end_o,
  output logic                         all_taken_o,
  output logic                         run_o
);
  localparam int CW    = LIMIT_W + UNIT_LOG2;
  localparam int IDX_W = $clog2(ATOM_LEN);

  logic [CW-1:0] cnt_q, total_q;
  logic          run_q;
  logic          last_one;

  assign take_o      = run_q && !start_i && sample_en_i && (cnt_q != total_q);
  assign last_one    = (cnt_q + CW'(1)) == total_q;
  assign bit_idx_o   = cnt_q[IDX_W-1:0];
  assign atom_end_o  = take_o && ((bit_idx_o == IDX_W'(ATOM_LEN - 1)) || last_one);
  assign all_taken_o = (cnt_q == total_q);
  assign run_o       = run_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      total_q <= '0;
      run_q   <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      total_q <= {limit_i, {UNIT_LOG2{1'b0}}};
      run_q   <= 1'b1;
    end else if (take_o) begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/pk_fill_bank.sv
module pk_fill_bank #(
  parameter int NUM_CH   = 16,
  parameter int ATOM_LEN = 64
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic                               take_i,
  input  logic                               atom_end_i,
  input  logic [$clog2(ATOM_LEN)-1:0]        bit_idx_i,
  input  logic [NUM_CH-1:0]                  sample_i,
  output logic [NUM_CH-1:0][ATOM_LEN-1:0]    words_o
);
  // One shift-free lane per channel: the sample bit lands at its atom position.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [ATOM_LEN-1:0] lane_q, lane_nxt;

    always_comb begin
      lane_nxt = lane_q;
      if (take_i) lane_nxt[bit_idx_i] = sample_i[ch];
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni)                    lane_q <= '0;
      else if (start_i || atom_end_i) lane_q <= '0;
      else                            lane_q <= lane_nxt;
    end

    assign words_o[ch] = lane_nxt;
  end
endmodule

// File: rtl/pk_drain_seq.sv
module pk_drain_seq
  import packer_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int ATOM_LEN = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic                             load_i,
  input  logic [NUM_CH-1:0][ATOM_LEN-1:0]  load_words_i,
  input  logic [NUM_CH-1:0]                load_mask_i,
  input  logic                             ready_i,
  output logic                             valid_o,
  output logic [ATOM_LEN-1:0]              data_o,
  output logic                             busy_o,
  output logic                             free_o
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0]               pending_q, sel_oh, rest;
  logic [NUM_CH-1:0][ATOM_LEN-1:0] buf_q;
  logic [SEL_W-1:0]                sel_idx;
  logic                            fire;

  assign sel_idx = SEL_W'(first_set(32'(pending_q)));
  assign sel_oh  = NUM_CH'(1) << sel_idx;
  assign rest    = pending_q & ~sel_oh;
  assign valid_o = |pending_q;
  assign busy_o  = valid_o;
  assign fire    = valid_o && ready_i;
  assign free_o  = !valid_o || (fire && (rest == '0));
  assign data_o  = buf_q[sel_idx];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pending_q <= '0;
      buf_q     <= '0;
    end else if (start_i) begin
      pending_q <= '0;
    end else if (load_i) begin
      pending_q <= load_mask_i;
      buf_q     <= load_words_i;
    end else if (fire) begin
      pending_q <= rest;
    end
  end
endmodule

// File: rtl/chan_word_packer.sv
module chan_word_packer #(
  parameter int NUM_CH    = 16,
  parameter int ATOM_LEN  = 64,
  parameter int LIMIT_W   = 24,
  parameter int UNIT_LOG2 = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sample_en_i,
  input  logic [NUM_CH-1:0]   sample_i,
  input  logic [NUM_CH-1:0]   chan_mask_i,
  input  logic [LIMIT_W-1:0]  limit_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [ATOM_LEN-1:0] out_data_o,
  output logic                done_o,
  output logic                overflow_o
);
  localparam int IDX_W = $clog2(ATOM_LEN);

  logic [NUM_CH-1:0]               mask_q;
  logic                            take, atom_end, all_taken, run;
  logic [IDX_W-1:0]                bit_idx;
  logic [NUM_CH-1:0][ATOM_LEN-1:0] fill_words;
  logic                            drain_busy, drain_free, handoff;
  logic                            ovf_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      mask_q <= '0;
    else if (start_i) mask_q <= chan_mask_i;
  end

  pk_sample_counter #(
    .LIMIT_W(LIMIT_W), .UNIT_LOG2(UNIT_LOG2), .ATOM_LEN(ATOM_LEN)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .sample_en_i(sample_en_i), .limit_i(limit_i),
    .take_o(take), .bit_idx_o(bit_idx), .atom_end_o(atom_end),
    .all_taken_o(all_taken), .run_o(run)
  );

  pk_fill_bank #(.NUM_CH(NUM_CH), .ATOM_LEN(ATOM_LEN)) u_fill (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .take_i(take), .atom_end_i(atom_end), .bit_idx_i(bit_idx),
    .sample_i(sample_i), .words_o(fill_words)
  );

  assign handoff = atom_end && drain_free;

  pk_drain_seq #(.NUM_CH(NUM_CH), .ATOM_LEN(ATOM_LEN)) u_drain (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_i(handoff), .load_words_i(fill_words), .load_mask_i(mask_q),
    .ready_i(out_ready_i), .valid_o(out_valid_o), .data_o(out_data_o),
    .busy_o(drain_busy), .free_o(drain_free)
  );

  // A completed atom with no room in the drain buffer is dropped and flagged.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (start_i)                 ovf_q <= 1'b0;
    else if (atom_end && !drain_free) ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;
  assign done_o     = run && all_taken && !drain_busy;
endmodule

// File: rtl/pk_packer_checker.sv
module pk_packer_checker #(
  parameter int ATOM_LEN = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [ATOM_LEN-1:0] out_data_o,
  input logic                done_o,
  input logic                overflow_o
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !start_i) |=> overflow_o);

  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o);

  assert_start_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!overflow_o && !out_valid_o));
endmodule

bind chan_word_packer pk_packer_checker #(.ATOM_LEN(ATOM_LEN)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .done_o(done_o), .overflow_o(overflow_o)
);

// File: tb/test_chan_word_packer.sv
module test_chan_word_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sample_en = 1'b0, out_ready = 1'b0;
  logic [15:0] sample = '0, chan_mask = '0;
  logic [23:0] limit = '0;
  logic        out_valid, done, overflow;
  logic [63:0] out_data;

  always #10 clk = ~clk;

  chan_word_packer i_chan_word_packer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sample_en_i(sample_en),
    .sample_i(sample), .chan_mask_i(chan_mask), .limit_i(limit),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .done_o(done), .overflow_o(overflow)
  );

  int checks = 0, errors = 0, cyc = 0;
  int ready_mode = 1;            // 0 hold low, 1 always high, 2 random
  logic [63:0] got[$];
  logic [63:0] exp_q[$];
  logic [15:0] smp[$];
  int last_hs = -10, done_rise = -10;
  bit stalled = 0, done_prev = 0;
  logic [63:0] stall_data;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Consumer and output monitor
  always @(negedge clk) begin
    if (rst_n && stalled)
      chk(out_valid && out_data == stall_data, "R8", "stalled word held",
          out_data, stall_data);
    case (ready_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = ($urandom % 10) < 7;
    endcase
    if (out_valid && out_ready) begin
      got.push_back(out_data);
      last_hs = cyc;
    end
    stalled    = out_valid && !out_ready;
    stall_data = out_data;
    if (done && !done_prev) done_rise = cyc;
    done_prev  = done;
  end

  task automatic do_start(input logic [15:0] m, input logic [23:0] l);
    @(negedge clk);
    got.delete();
    smp.delete();
    chan_mask = m;
    limit     = l;
    start     = 1'b1;
    sample_en = 1'b1;          // same-cycle sample must be ignored (R7)
    sample    = 16'hFFFF;
    @(negedge clk);
    start     = 1'b0;
    sample_en = 1'b0;
    chan_mask = 16'($urandom); // later changes ignored (R7)
    limit     = 24'($urandom % 4);
  endtask

  task automatic feed(input int n, input int dens);
    int k = 0;
    while (k < n) begin
      sample_en = ($urandom % 100) < dens;
      sample    = 16'($urandom);
      if (sample_en) begin
        smp.push_back(sample);
        k++;
      end
      @(negedge clk);
    end
    sample_en = 1'b0;
  endtask

  function automatic void build(input logic [15:0] m, input int total);
    int atoms = (total + 63) / 64;
    exp_q.delete();
    for (int a = 0; a < atoms; a++)
      for (int ch = 0; ch < 16; ch++)
        if (m[ch]) begin
          logic [63:0] w = '0;
          for (int n = 0; n < 64; n++)
            if (a * 64 + n < total) w[n] = smp[a * 64 + n][ch];
          exp_q.push_back(w);
        end
  endfunction

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done, req, "done reached", 64'(done), 64'd1);
  endtask

  task automatic compare(input string req);
    chk(got.size() == exp_q.size(), "R4", {req, " word count"},
        64'(got.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], "R2/R3", {req, " word value"}, got[i], exp_q[i]);
    if (exp_q.size() > 0)
      chk(done_rise == last_hs + 1, "R10", {req, " done timing"},
          64'(done_rise), 64'(last_hs + 1));
    chk(!out_valid, "R10", {req, " valid low at done"}, 64'(out_valid), 64'd0);
  endtask

  task automatic run_capture(input logic [15:0] m, input int units,
                             input int dens, input int extra, input string req);
    do_start(m, 24'(units));
    feed(units * 16 + extra, dens);
    wait_done(req);
    repeat (2) @(negedge clk);
    build(m, units * 16);
    compare(req);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && !overflow, "R1", "reset state",
        {61'd0, out_valid, done, overflow}, 64'd0);
    // samples before any start
    sample_en = 1'b1;
    repeat (70) @(negedge clk);
    sample_en = 1'b0;
    chk(!out_valid && !done, "R1", "no output before start",
        {62'd0, out_valid, done}, 64'd0);

    // full atom, all channels, dense
    ready_mode = 1;
    run_capture(16'hFFFF, 4, 100, 0, "R2 full atom");

    // sparse mask, partial final atom, random ready, extra samples beyond limit
    ready_mode = 2;
    run_capture(16'h8421, 5, 60, 30, "R6 pad partial");

    // limit zero
    do_start(16'h00FF, 24'd0);
    chk(done, "R5", "limit 0 done after start", 64'(done), 64'd1);
    feed(40, 100);
    repeat (3) @(negedge clk);
    chk(got.size() == 0, "R5", "limit 0 no words", 64'(got.size()), 64'd0);

    // zero mask
    run_capture(16'h0000, 3, 80, 5, "R4 zero mask");

    // restart mid-capture discards partial state
    do_start(16'h0F0F, 24'd10);
    feed(30, 100);
    run_capture(16'hA005, 2, 70, 10, "R7 restart");

    // overflow: ready held low across two atoms
    ready_mode = 0;
    do_start(16'h0013, 24'd8);
    feed(128, 100);
    repeat (3) @(negedge clk);
    chk(overflow, "R9", "overflow raised", 64'(overflow), 64'd1);
    chk(out_valid && !done, "R9", "first atom still pending",
        {62'd0, out_valid, done}, 64'd2);
    ready_mode = 1;
    wait_done("R9");
    repeat (2) @(negedge clk);
    build(16'h0013, 128);
    while (exp_q.size() > 3) void'(exp_q.pop_back());
    compare("R9 dropped atom");
    chk(overflow, "R9", "overflow sticky", 64'(overflow), 64'd1);

    // random captures
    ready_mode = 2;
    for (int r = 0; r < 8; r++) begin
      run_capture(16'($urandom), 1 + ($urandom % 12), 50, 20, "R3 random");
      chk(!overflow, "R7", "overflow cleared, none raised", 64'(overflow), 64'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule